// File: doc/BRIEF.md
# Serial Transmit Byte Queue with Direct Load

This block is the sending half of an asynchronous serial port. A register interface writes bytes into an eight-entry first-in first-out queue. The head byte then moves into a shift register that sends each byte as one frame on a serial line. A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. A 16-bit reload counter sets the length of each bit. When the line is idle it stays high.

A byte may be written while the queue is empty and the shifter is free. That byte skips the queue and starts at once. The queue level is always visible as a count. Two single-cycle interrupt pulses report progress. The buffer pulse marks the start of a frame in two cases: the byte came by the direct path, or the queue level left behind equals a programmable trigger. The completion pulse marks the end of every frame.

Software may turn the queue off. This flushes its contents, and the block then holds at most one byte waiting behind the shifter. A write that finds no room is dropped and sets a sticky flag. Software clears the flag by writing a one to it.

Top module: `ser_tx_queue`

## Requirements
- R1: After reset, txd is 1, fill_level is 0, and ovf_flag, buf_irq and done_irq are all 0.
- R2: Each frame is sent as a 0 start bit, then wr_data bits 0 to 7 in that order, then a 1 stop bit. Every bit lasts bit_reload+1 clock cycles. The line is 1 between frames.
- R3: A write that finds the queue empty and the shifter free loads the shifter directly. In the next cycle txd is 0, fill_level stays 0 and buf_irq pulses.
- R4: Bytes written while a frame is in progress are queued, and each accepted write raises fill_level by one. All accepted bytes go out in the order they were written.
- R5: fill_level gives the number of queued bytes, 0 to 8. It does not count the byte in the shifter. It reads 0 from the cycle the last queued byte starts its frame.
- R6: When a byte moves from the queue to the shifter, buf_irq pulses for one cycle, aligned with that frame's start bit, if and only if the queue level after that cycle equals trig_level. Buffer pulses have no other cause except R3.
- R7: done_irq pulses for one cycle, in the cycle after the stop bit's last cycle, which is exactly 10*(bit_reload+1) cycles after the frame's start bit appears.
- R8: A write that finds the queue full is dropped, leaves the queued bytes unchanged and sets ovf_flag. The flag stays set until a cycle with ovf_clr=1 and no new overflow.
- R9: When queue_on goes from 1 to 0, all queued bytes are discarded in that cycle. While queue_on is 0, at most one byte waits behind the shifter, and further writes overflow as in R8.
- R10: A write and a move into the shifter in the same cycle are both carried out. A queued byte starts its frame in the cycle right after the previous stop bit ends, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to send |
| queue_on | input | 1 | 1: eight-entry queue; 0: single waiting byte |
| trig_level | input | 4 | Queue level that triggers buf_irq on a move into the shifter |
| bit_reload | input | 16 | Bit length minus one, in clock cycles |
| ovf_clr | input | 1 | Writing 1 clears ovf_flag |
| txd | output | 1 | Serial line, idle high |
| fill_level | output | 4 | Number of queued bytes |
| ovf_flag | output | 1 | Sticky overflow indication |
| buf_irq | output | 1 | Buffer interrupt pulse |
| done_irq | output | 1 | Frame complete pulse |

## Verification
A wrong queue count or pointer shows at the ports within one frame. It appears as a wrong fill_level, as a missing or extra buffer pulse on the next move into the shifter, or as a byte received out of order or repeated. A wrong bit counter or baud divider shows as wrong serial data. It also moves done_irq away from the exact 10*(bit_reload+1) cycle mark. A lost same-cycle write or move shows up as a missing byte or as a gap between frames. The bench decodes the line independently, sampling the middle of each bit, and compares every byte and pulse count against values derived from the requirements.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Source selected for the next shifter load
  typedef enum logic [1:0] {
    LD_NONE   = 2'd0,
    LD_DIRECT = 2'd1,
    LD_QUEUED = 2'd2
  } ld_src_t;
endpackage

// File: rtl/txq_baud.sv
module txq_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // One tick every reload+1 cycles while running; restart aligns to a frame start
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= reload;
    end else if (run) begin
      if (cnt == '0) cnt <= reload;
      else           cnt <= cnt - DIV_W'(1);
    end
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count
);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  // Storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  generate
    if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + ADDR_W'(1);
      assign rd_nxt = rd_ptr + ADDR_W'(1);
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == ADDR_W'(DEPTH - 1)) ? '0 : wr_ptr + ADDR_W'(1);
      assign rd_nxt = (rd_ptr == ADDR_W'(DEPTH - 1)) ? '0 : rd_ptr + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/txq_shift.sv
module txq_shift #(
  parameter int DATA_W = 8,
  localparam int FR_W  = DATA_W + 2,
  localparam int BIT_W = $clog2(FR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] ldata,
  input  logic              tick,
  output logic              busy,
  output logic              ready,
  output logic              done,
  output logic              txd
);
  logic [FR_W-1:0]  shreg;
  logic [BIT_W-1:0] bit_idx;
  logic             last;

  assign last  = busy && tick && (bit_idx == BIT_W'(FR_W - 1));
  assign ready = !busy || last;
  assign done  = last;
  assign txd   = shreg[0];

  // Frame is {stop, data, start}, shifted out from bit 0; all ones when idle
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '1;
      bit_idx <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      shreg   <= {1'b1, ldata, 1'b0};
      bit_idx <= '0;
      busy    <= 1'b1;
    end else if (last) begin
      shreg   <= '1;
      bit_idx <= '0;
      busy    <= 1'b0;
    end else if (busy && tick) begin
      shreg   <= {1'b1, shreg[FR_W-1:1]};
      bit_idx <= bit_idx + BIT_W'(1);
    end
  end
endmodule

// File: rtl/ser_tx_queue.sv
module ser_tx_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              queue_on,
  input  logic [CNT_W-1:0]  trig_level,
  input  logic [DIV_W-1:0]  bit_reload,
  input  logic              ovf_clr,
  output logic              txd,
  output logic [CNT_W-1:0]  fill_level,
  output logic              ovf_flag,
  output logic              buf_irq,
  output logic              done_irq
);
  import txq_pkg::*;

  logic              queue_on_q, flush;
  logic [CNT_W-1:0]  q_count, cap, next_level;
  logic [DATA_W-1:0] q_rdata, sh_data;
  logic              q_empty, q_full;
  logic              direct, push, pop, ovf_set, buf_hit;
  logic              sh_busy, sh_ready, sh_done, tick;
  ld_src_t           ld_src;

  always_ff @(posedge clk) begin
    if (rst) queue_on_q <= 1'b0;
    else     queue_on_q <= queue_on;
  end

  assign flush   = queue_on_q && !queue_on;
  assign cap     = queue_on ? CNT_W'(DEPTH) : CNT_W'(1);
  assign q_empty = (q_count == '0);
  assign q_full  = (q_count >= cap);

  // Direct path when nothing waits and the shifter can take a byte now
  assign direct  = wr_en && sh_ready && q_empty;
  assign pop     = sh_ready && !q_empty && !flush;
  assign push    = wr_en && !direct && !q_full && !flush;
  assign ovf_set = wr_en && !direct && q_full && !flush;

  always_comb begin
    if (direct)   ld_src = LD_DIRECT;
    else if (pop) ld_src = LD_QUEUED;
    else          ld_src = LD_NONE;
  end

  assign sh_data    = (ld_src == LD_DIRECT) ? wr_data : q_rdata;
  assign next_level = q_count + CNT_W'(push) - CNT_W'(pop);
  assign buf_hit    = (ld_src == LD_DIRECT) ||
                      ((ld_src == LD_QUEUED) && (next_level == trig_level));

  txq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .flush (flush),
    .wdata (wr_data),
    .rdata (q_rdata),
    .count (q_count)
  );

  txq_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (ld_src != LD_NONE),
    .run     (sh_busy),
    .reload  (bit_reload),
    .tick    (tick)
  );

  txq_shift #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (ld_src != LD_NONE),
    .ldata (sh_data),
    .tick  (tick),
    .busy  (sh_busy),
    .ready (sh_ready),
    .done  (sh_done),
    .txd   (txd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_irq  <= 1'b0;
      done_irq <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      buf_irq  <= buf_hit;
      done_irq <= sh_done;
      if (ovf_set)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  assign fill_level = q_count;
endmodule

// File: rtl/ser_tx_queue_chk.sv
module ser_tx_queue_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             queue_on,
  input logic             ovf_clr,
  input logic             txd,
  input logic [CNT_W-1:0] fill_level,
  input logic             ovf_flag,
  input logic             buf_irq,
  input logic             done_irq
);
  p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
    int'(fill_level) <= DEPTH);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !ovf_clr |=> ovf_flag);

  p_ovf_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_clr && !wr_en |=> !ovf_flag);

  p_single_slot_r9: assert property (@(posedge clk) disable iff (rst)
    !queue_on && $past(!queue_on) |-> int'(fill_level) <= 1);

  p_buf_start_r6: assert property (@(posedge clk) disable iff (rst)
    buf_irq |-> !txd);

  p_buf_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    buf_irq |=> !buf_irq);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  p_level_step_r10: assert property (@(posedge clk) disable iff (rst)
    queue_on && $past(queue_on) |->
      (int'(fill_level) <= int'($past(fill_level)) + 1) &&
      (int'(fill_level) + 1 >= int'($past(fill_level))));
endmodule

bind ser_tx_queue ser_tx_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .queue_on   (queue_on),
  .ovf_clr    (ovf_clr),
  .txd        (txd),
  .fill_level (fill_level),
  .ovf_flag   (ovf_flag),
  .buf_irq    (buf_irq),
  .done_irq   (done_irq)
);

// File: tb/ser_tx_queue_bench.sv
module ser_tx_queue_bench;
  localparam int CLK_P = 10;
  localparam int RL    = 3;
  localparam int BL    = RL + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       queue_on = 1'b1;
  logic [3:0] trig_level = 4'd15;
  logic [15:0] bit_reload = 16'(RL);
  logic       ovf_clr = 1'b0;
  logic       txd;
  logic [3:0] fill_level;
  logic       ovf_flag, buf_irq, done_irq;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  ser_tx_queue u_ser_tx_queue (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .queue_on(queue_on), .trig_level(trig_level), .bit_reload(bit_reload),
    .ovf_clr(ovf_clr), .txd(txd), .fill_level(fill_level),
    .ovf_flag(ovf_flag), .buf_irq(buf_irq), .done_irq(done_irq)
  );

  // Independent line decoder and pulse counters, sampled at the falling edge
  int         buf_seen = 0, done_seen = 0;
  logic [7:0] rx_q [0:63];
  int         rx_n = 0;
  int         rx_ph = -1;
  logic [7:0] rx_sh;
  int         stop_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (buf_irq)  buf_seen++;
      if (done_irq) done_seen++;
      if (rx_ph < 0) begin
        if (!txd) rx_ph = 0;
      end else begin
        rx_ph++;
        for (int i = 0; i < 8; i++)
          if (rx_ph == BL*(1+i) + BL/2) rx_sh[i] = txd;
        if (rx_ph == BL*9 + BL/2) begin
          if (!txd) stop_bad++;
          if (rx_n < 64) rx_q[rx_n] = rx_sh;
          rx_n++;
          rx_ph = -1;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic write(logic [7:0] b);
    wr_en = 1'b1;
    wr_data = b;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_done(int target);
    int n = 0;
    while (done_seen < target && n < 5000) begin
      step();
      n++;
    end
    if (done_seen < target) chk("R7", "done pulse timeout", done_seen, target);
  endtask

  task automatic t_reset();
    chk("R1", "txd idle", int'(txd), 1);
    chk("R1", "fill after reset", int'(fill_level), 0);
    chk("R1", "ovf after reset", int'(ovf_flag), 0);
    chk("R1", "buf_irq after reset", int'(buf_irq), 0);
    chk("R1", "done_irq after reset", int'(done_irq), 0);
  endtask

  task automatic t_direct();
    int r0 = rx_n;
    int k = 0;
    write(8'hA5);
    chk("R3", "start bit after direct write", int'(txd), 0);
    chk("R3", "fill after direct write", int'(fill_level), 0);
    chk("R3", "buf_irq on direct write", int'(buf_irq), 1);
    while (!done_irq && k < 1000) begin
      step();
      k++;
    end
    chk("R7", "cycles from start to done", k, 10*BL);
    chk("R2", "line idle after frame", int'(txd), 1);
    step();
    chk("R7", "done pulse one cycle", int'(done_irq), 0);
    chk("R2", "byte decoded", int'(rx_q[r0]), 8'hA5);
    chk("R2", "stop bits", stop_bad, 0);
  endtask

  task automatic t_order();
    int r0 = rx_n, d0 = done_seen, b0 = buf_seen;
    logic [7:0] exp [7] = '{8'h11, 8'h22, 8'h3C, 8'h4D, 8'h5E, 8'h6F, 8'h70};
    trig_level = 4'd3;
    for (int i = 0; i < 6; i++) begin
      wr_en = 1'b1;
      wr_data = exp[i];
      step();
    end
    wr_en = 1'b0;
    chk("R4", "fill after six writes", int'(fill_level), 5);
    wait_done(d0 + 3);
    chk("R5", "fill while fourth byte sends", int'(fill_level), 2);
    chk("R6", "buffer pulses so far", buf_seen - b0, 2);
    write(exp[6]);
    chk("R4", "fill after late write", int'(fill_level), 3);
    wait_done(d0 + 6);
    chk("R5", "fill zero as last byte starts", int'(fill_level), 0);
    chk("R10", "no gap before last frame", int'(txd), 0);
    wait_done(d0 + 7);
    repeat (BL) step();
    chk("R4", "bytes received", rx_n - r0, 7);
    for (int i = 0; i < 7; i++)
      chk("R4", "byte order", int'(rx_q[r0+i]), int'(exp[i]));
    chk("R6", "buffer pulses total", buf_seen - b0, 2);
  endtask

  task automatic t_trig_zero();
    int d0 = done_seen, b0 = buf_seen;
    trig_level = 4'd0;
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1;
      wr_data = 8'(8'h80 + i);
      step();
    end
    wr_en = 1'b0;
    wait_done(d0 + 3);
    chk("R6", "trigger zero pulses", buf_seen - b0, 2);
  endtask

  task automatic t_overflow();
    int r0 = rx_n, d0 = done_seen, b0 = buf_seen;
    trig_level = 4'd15;
    for (int i = 0; i < 9; i++) begin
      wr_en = 1'b1;
      wr_data = 8'(8'hC0 + i);
      step();
    end
    wr_en = 1'b0;
    chk("R8", "queue full", int'(fill_level), 8);
    chk("R8", "no overflow yet", int'(ovf_flag), 0);
    write(8'hEE);
    chk("R8", "overflow flag set", int'(ovf_flag), 1);
    chk("R8", "fill unchanged on drop", int'(fill_level), 8);
    repeat (5) step();
    chk("R8", "flag sticky", int'(ovf_flag), 1);
    ovf_clr = 1'b1;
    step();
    ovf_clr = 1'b0;
    chk("R8", "flag cleared", int'(ovf_flag), 0);
    wait_done(d0 + 9);
    repeat (12*BL) step();
    chk("R8", "bytes received", rx_n - r0, 9);
    for (int i = 0; i < 9; i++)
      chk("R8", "kept bytes", int'(rx_q[r0+i]), 8'hC0 + i);
    chk("R6", "only direct pulse", buf_seen - b0, 1);
  endtask

  task automatic t_single();
    int r0 = rx_n, d0 = done_seen;
    queue_on = 1'b0;
    step();
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1;
      wr_data = 8'(8'h31 + i);
      step();
    end
    wr_en = 1'b0;
    chk("R9", "single slot fill", int'(fill_level), 1);
    chk("R9", "third write overflows", int'(ovf_flag), 1);
    ovf_clr = 1'b1;
    step();
    ovf_clr = 1'b0;
    wait_done(d0 + 2);
    repeat (12*BL) step();
    chk("R9", "bytes in single mode", rx_n - r0, 2);
    chk("R9", "first byte", int'(rx_q[r0]), 8'h31);
    chk("R9", "second byte", int'(rx_q[r0+1]), 8'h32);
    // flush on disable
    queue_on = 1'b1;
    step();
    r0 = rx_n;
    d0 = done_seen;
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1;
      wr_data = 8'(8'h91 + i);
      step();
    end
    wr_en = 1'b0;
    chk("R9", "fill before flush", int'(fill_level), 2);
    queue_on = 1'b0;
    step();
    chk("R9", "fill after flush", int'(fill_level), 0);
    wait_done(d0 + 1);
    repeat (12*BL) step();
    chk("R9", "bytes after flush", rx_n - r0, 1);
    chk("R9", "byte kept by shifter", int'(rx_q[r0]), 8'h91);
    queue_on = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_direct();
    t_order();
    t_trig_zero();
    t_overflow();
    t_single();
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule